// File: doc/BRIEF.md
# DSP Bit-Field Insert Unit

This execution unit serves a DSP-extended processor datapath and performs one of two bit-manipulation operations per request. The first mirrors the low 16 bits of an operand: bit 0 swaps with bit 15, bit 1 with bit 14, and so on. The second copies a contiguous field out of one operand (the insert source) into a second operand (the keep source). The field's starting bit and length are not encoded in the instruction. They come from two fields of the DSP control-register value presented alongside the operands.

A request is one cycle with `in_valid` high. The unit registers its answer, so `out_valid` and `result` appear on the following clock edge. A narrow (32-bit) insert produces a 32-bit word that is sign-extended to the full register width. A wide (64-bit) insert produces the full-width word as it stands. An impossible field geometry leaves the keep source untouched. Decode, register-file access, hazards and control-register updates belong to the surrounding pipeline.

Top module: `bfins_unit`

## Requirements
- R1: On a synchronous active-high reset, `out_valid` and `result` go to zero on the next clock edge.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `result` keeps its value whenever `in_valid` was low.
- R3: With `op_sel` = 0 (reverse), result bit i equals `src_keep` bit 15-i for i in 0..15, and result bits 63:16 are zero. `wide_mode` and `ctrl_word` have no effect on this operation.
- R4: With `op_sel` = 1 (insert) and `wide_mode` = 0, the field start `lo` is `ctrl_word[4:0]` and the field length `len` is `ctrl_word[11:7]`.
- R5: With `op_sel` = 1 and `wide_mode` = 1, `lo` is `ctrl_word[6:0]` and `len` is `ctrl_word[12:7]`.
- R6: The field top is `hi = lo + len - 1`, computed as 32-bit unsigned arithmetic. The geometry is invalid when `lo > hi` (this includes `len` = 0) or when `hi` exceeds the word width (32 narrow, 64 wide). An invalid geometry returns `src_keep` unmodified at full width.
- R7: For a valid geometry, bits `lo..hi` that lie below the word width come from `src_ins`, and every other bit comes from `src_keep`. A field with `hi` equal to the word width is legal, and its top bit is dropped.
- R8: A narrow insert with a valid geometry returns the merged bits 31:0, with bit 31 copied into bits 63:32.
- R9: A wide insert with a valid geometry returns all 64 merged bits without extension.
- R10: Bits of `ctrl_word` outside the position and length fields do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe, one cycle per operation |
| op_sel | input | 1 | 0 = reverse low 16 bits, 1 = field insert |
| wide_mode | input | 1 | 0 = 32-bit insert, 1 = 64-bit insert |
| ctrl_word | input | 32 | Current DSP control-register value |
| src_ins | input | 64 | Operand supplying the field bits |
| src_keep | input | 64 | Operand kept outside the field; also the operand reversed |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Registered result word |

## Verification
On every cycle the assertions check the one-cycle valid timing and the reset values. They also check that `result` holds between requests, that the upper bits of a reverse are zero, and that an invalid geometry passes the keep operand through. They further check the sign extension of narrow inserts. Whether the right bits were mirrored or merged, and whether the position and length fields were read from the correct control bits, can only be shown by the bench. The bench compares random and directed requests with its own model. Its directed cases include a field at bit 0, a zero length, a field ending at the top bit, and a field one or two bits past the word width.

// File: rtl/bfins_pkg.sv
package bfins_pkg;

  typedef enum logic {
    OP_BITREV = 1'b0,
    OP_INSERT = 1'b1
  } bf_op_e;

  // Control-register field layout (the pipeline decodes these positions).
  localparam int unsigned LEN_LSB  = 7;
  localparam int unsigned NPOS_W   = 5;
  localparam int unsigned WPOS_W   = 7;
  localparam int unsigned NLEN_W   = 5;
  localparam int unsigned WLEN_W   = 6;
  localparam int unsigned FIELD_HI = LEN_LSB + WLEN_W;   // first unused ctrl bit
  localparam int unsigned GEOM_W   = 32;                 // width of geometry arithmetic
  localparam int unsigned REV_W    = 16;

  typedef logic [GEOM_W-1:0] geom_word_t;

  typedef struct packed {
    geom_word_t lo;
    geom_word_t hi;
    logic       bad;
  } geom_t;

  // Top bit of the field; unsigned wrap when len is zero is intended.
  function automatic geom_word_t field_top(geom_word_t lo, geom_word_t len);
    return lo + len - geom_word_t'(1);
  endfunction

  // True when a field cannot be placed inside a word of the given width.
  function automatic logic geom_invalid(geom_word_t lo, geom_word_t hi, geom_word_t width);
    return (lo > hi) || (hi > width);
  endfunction

  // Field membership of one bit position.
  function automatic logic in_field(geom_word_t bitpos, geom_t g);
    return !g.bad && (bitpos >= g.lo) && (bitpos <= g.hi);
  endfunction

endpackage

// File: rtl/bfins_geom.sv
module bfins_geom
  import bfins_pkg::*;
#(
  parameter int unsigned CTRL_W   = 32,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned WIDE_W   = 64
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              wide,
  output geom_t             geom
);

  localparam geom_word_t NARROW_LIM = geom_word_t'(NARROW_W);
  localparam geom_word_t WIDE_LIM   = geom_word_t'(WIDE_W);

  geom_word_t lo_n, lo_w, len_n, len_w;
  geom_word_t lo_sel, len_sel, lim_sel, hi_sel;

  assign lo_n  = geom_word_t'(ctrl[NPOS_W-1:0]);
  assign lo_w  = geom_word_t'(ctrl[WPOS_W-1:0]);
  assign len_n = geom_word_t'(ctrl[LEN_LSB +: NLEN_W]);
  assign len_w = geom_word_t'(ctrl[LEN_LSB +: WLEN_W]);

  // Control bits outside the two fields are deliberately ignored.
  logic unused_ctrl_bits;
  assign unused_ctrl_bits = ^ctrl[CTRL_W-1:FIELD_HI];

  always_comb begin
    lo_sel  = wide ? lo_w  : lo_n;
    len_sel = wide ? len_w : len_n;
    lim_sel = wide ? WIDE_LIM : NARROW_LIM;
    hi_sel  = field_top(lo_sel, len_sel);
    geom.lo  = lo_sel;
    geom.hi  = hi_sel;
    geom.bad = geom_invalid(lo_sel, hi_sel, lim_sel);
  end

endmodule

// File: rtl/bfins_mask.sv
module bfins_mask
  import bfins_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  geom_t            geom,
  output logic [XLEN-1:0]  mask
);

  // Bits above XLEN never exist here, so out-of-range mask bits drop away.
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign mask[i] = in_field(geom_word_t'(i), geom);
  end

endmodule

// File: rtl/bfins_bitrev.sv
module bfins_bitrev
  import bfins_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [REV_W-1:0] din,
  output logic [XLEN-1:0]  dout
);

  for (genvar i = 0; i < REV_W; i++) begin : g_swap
    assign dout[i] = din[REV_W-1-i];
  end
  assign dout[XLEN-1:REV_W] = '0;

endmodule

// File: rtl/bfins_merge.sv
module bfins_merge #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input  logic [XLEN-1:0] ins_src,
  input  logic [XLEN-1:0] keep_src,
  input  logic [XLEN-1:0] mask,
  input  logic            wide,
  input  logic            bad,
  output logic [XLEN-1:0] dout
);

  localparam int unsigned EXT_W = XLEN - NARROW_W;

  logic [XLEN-1:0] merged;
  logic [XLEN-1:0] narrow_ext;

  assign merged     = (ins_src & mask) | (keep_src & ~mask);
  assign narrow_ext = {{EXT_W{merged[NARROW_W-1]}}, merged[NARROW_W-1:0]};

  always_comb begin
    if (bad)       dout = keep_src;
    else if (wide) dout = merged;
    else           dout = narrow_ext;
  end

endmodule

// File: rtl/bfins_unit.sv
module bfins_unit
  import bfins_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned CTRL_W   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            op_sel,
  input  logic            wide_mode,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic [XLEN-1:0] src_ins,
  input  logic [XLEN-1:0] src_keep,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);

  bf_op_e          op;
  geom_t           geom;
  logic            geom_bad;
  logic [XLEN-1:0] field_mask;
  logic [XLEN-1:0] rev_value;
  logic [XLEN-1:0] ins_value;
  logic [XLEN-1:0] next_result;

  assign op       = bf_op_e'(op_sel);
  assign geom_bad = geom.bad;

  bfins_geom #(
    .CTRL_W  (CTRL_W),
    .NARROW_W(NARROW_W),
    .WIDE_W  (XLEN)
  ) u_geom (
    .ctrl(ctrl_word),
    .wide(wide_mode),
    .geom(geom)
  );

  bfins_mask #(.XLEN(XLEN)) u_mask (
    .geom(geom),
    .mask(field_mask)
  );

  bfins_bitrev #(.XLEN(XLEN)) u_rev (
    .din (src_keep[REV_W-1:0]),
    .dout(rev_value)
  );

  bfins_merge #(
    .XLEN    (XLEN),
    .NARROW_W(NARROW_W)
  ) u_merge (
    .ins_src (src_ins),
    .keep_src(src_keep),
    .mask    (field_mask),
    .wide    (wide_mode),
    .bad     (geom_bad),
    .dout    (ins_value)
  );

  assign next_result = (op == OP_INSERT) ? ins_value : rev_value;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end

endmodule

// File: rtl/bfins_checks.sv
module bfins_checks #(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned NARROW_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            op_sel,
  input logic            wide_mode,
  input logic [XLEN-1:0] src_keep,
  input logic            geom_bad,
  input logic            out_valid,
  input logic [XLEN-1:0] result
);

  localparam int unsigned EXT_W = XLEN - NARROW_W;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  a_r3_rev_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel) |=> (result[XLEN-1:16] == '0));

  a_r6_bad_passthru: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel && geom_bad) |=> (result == $past(src_keep)));

  a_r8_narrow_sext: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel && !wide_mode && !geom_bad) |=>
      (result[XLEN-1:NARROW_W] == {EXT_W{result[NARROW_W-1]}}));

endmodule

bind bfins_unit bfins_checks #(
  .XLEN    (XLEN),
  .NARROW_W(NARROW_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .op_sel   (op_sel),
  .wide_mode(wide_mode),
  .src_keep (src_keep),
  .geom_bad (geom_bad),
  .out_valid(out_valid),
  .result   (result)
);

// File: tb/sim_bfins_unit.sv
module sim_bfins_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        op_sel;
  logic        wide_mode;
  logic [31:0] ctrl_word;
  logic [63:0] src_ins;
  logic [63:0] src_keep;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bfins_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .wide_mode(wide_mode), .ctrl_word(ctrl_word), .src_ins(src_ins),
    .src_keep(src_keep), .out_valid(out_valid), .result(result)
  );

  // Reference: mirror the low 16 bits by walking them out one at a time.
  function automatic logic [63:0] ref_rev(logic [63:0] v);
    logic [63:0] acc = '0;
    logic [63:0] t = {48'd0, v[15:0]};
    for (int k = 0; k < 16; k++) begin
      acc = (acc << 1) | {63'd0, t[0]};
      t = t >> 1;
    end
    return acc;
  endfunction

  // Reference: build the mask wide, then clip to 64 bits and merge.
  function automatic logic [63:0] ref_ins(logic wide, logic [31:0] c,
                                          logic [63:0] a, logic [63:0] b);
    int unsigned lo, len, hi, lim;
    logic [191:0] f;
    logic [63:0] t;
    lo  = wide ? int'(c & 32'h7f) : int'(c & 32'h1f);
    len = wide ? int'((c >> 7) & 32'h3f) : int'((c >> 7) & 32'h1f);
    lim = wide ? 64 : 32;
    hi  = lo + len - 1;
    if (lo > hi || hi > lim) return b;
    f = ((192'd1 << len) - 192'd1) << lo;
    t = (a & f[63:0]) | (b & ~f[63:0]);
    if (!wide) t = {{32{t[31]}}, t[31:0]};
    return t;
  endfunction

  function automatic logic [31:0] mk_ctrl(int unsigned lo, int unsigned len);
    return ((len & 32'h3f) << 7) | (lo & 32'h7f);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One request; sample at the following falling edge.
  task automatic run_op(string req, logic op, logic wide, logic [31:0] c,
                        logic [63:0] a, logic [63:0] b, logic [63:0] exp);
    op_sel = op; wide_mode = wide; ctrl_word = c; src_ins = a; src_keep = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {63'd0, out_valid}, 64'd1);
    check(req, result, exp);
  endtask

  task automatic ins_case(string req, logic wide, logic [31:0] c,
                          logic [63:0] a, logic [63:0] b);
    run_op(req, 1'b1, wide, c, a, b, ref_ins(wide, c, a, b));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [63:0] a, b, held;
    logic [31:0] c;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; op_sel = 1'b0; wide_mode = 1'b0;
    ctrl_word = '0; src_ins = '0; src_keep = '0;
    @(negedge clk); @(negedge clk);
    check("R1 out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle", {63'd0, out_valid}, 64'd0);

    // R3 directed reverses, mode and ctrl ignored
    run_op("R3 single bit", 1'b0, 1'b0, 32'h0, 64'h0, 64'h1, 64'h8000);
    run_op("R3 pattern", 1'b0, 1'b1, 32'hffff_ffff, 64'h0,
           64'hdead_beef_0000_1234, 64'h0000_0000_0000_2c48);
    held = result;
    @(negedge clk);
    check("R2 no strobe", {63'd0, out_valid}, 64'd0);
    check("R2 hold", result, held);

    // R4 / R6 / R7 / R8 narrow corners
    a = 64'hffff_ffff_ffff_ffff; b = 64'h0;
    run_op("R4 lo0 len8", 1'b1, 1'b0, mk_ctrl(0, 8), a, b, 64'h0000_0000_0000_00ff);
    run_op("R6 len0 narrow", 1'b1, 1'b0, mk_ctrl(5, 0), a, 64'h1234_5678_9abc_def0,
           64'h1234_5678_9abc_def0);
    run_op("R8 top bit31", 1'b1, 1'b0, mk_ctrl(24, 8), a, b, 64'hffff_ffff_ff00_0000);
    run_op("R7 hi32 dropped", 1'b1, 1'b0, mk_ctrl(25, 8), a, b, 64'hffff_ffff_fe00_0000);
    run_op("R6 hi33 narrow", 1'b1, 1'b0, mk_ctrl(26, 8), a, 64'h0000_0000_0000_0055,
           64'h0000_0000_0000_0055);
    run_op("R8 positive", 1'b1, 1'b0, mk_ctrl(4, 4), 64'h0, 64'hffff_ffff_7fff_ffff,
           64'h0000_0000_7fff_ff0f);
    // R5 / R9 wide corners
    run_op("R9 top bit63", 1'b1, 1'b1, mk_ctrl(56, 8), a, b, 64'hff00_0000_0000_0000);
    run_op("R7 hi64 dropped", 1'b1, 1'b1, mk_ctrl(57, 8), a, b, 64'hfe00_0000_0000_0000);
    run_op("R6 hi65 wide", 1'b1, 1'b1, mk_ctrl(58, 8), a, 64'h0000_0000_0000_0077,
           64'h0000_0000_0000_0077);
    run_op("R5 lo100", 1'b1, 1'b1, mk_ctrl(100, 10), a, 64'h5, 64'h5);
    run_op("R5 lo0 len63", 1'b1, 1'b1, mk_ctrl(0, 63), a, b, 64'h7fff_ffff_ffff_ffff);
    run_op("R5 lo96 narrow-field", 1'b1, 1'b1, mk_ctrl(96, 0) | 32'h0000_0020, a, b, b);
    // R10 extra ctrl bits set
    run_op("R10 narrow extra bits", 1'b1, 1'b0, mk_ctrl(8, 8) | 32'hffff_e060, a, b,
           64'h0000_0000_0000_ff00);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      a = {$urandom(), $urandom()};
      b = {$urandom(), $urandom()};
      c = $urandom();
      if (i % 4 == 0)
        run_op("R3 random", 1'b0, i[1], c, a, b, ref_rev(b));
      else if (i % 4 == 1)
        ins_case("R4 R8 random narrow", 1'b0, c, a, b);
      else if (i % 4 == 2)
        ins_case("R5 R9 random wide", 1'b1, c & 32'h0000_1fbf, a, b);
      else
        ins_case("R10 random wide any ctrl", 1'b1, c, a, b);
    end

    // R1 reset mid-stream
    op_sel = 1'b1; wide_mode = 1'b1; ctrl_word = mk_ctrl(0, 8);
    src_ins = '1; src_keep = '0; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R1 reset wins valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset wins result", result, 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule